// File: doc/BRIEF.md
# Timer-Paced Serial Frame Trigger

This block sets the sampling rhythm of a serial converter link from a single master clock. A reloadable interval timer raises a request once per programmed interval. A programmable divider derives a free-running serial clock from the same master clock. Each request launches one active-low frame that stays asserted for a whole 16-bit word, so the frame output can drive a converter chip select with no glue logic.

A frame does not begin as soon as the timer fires. The sequencer first waits until the serial clock has been observed high, then low, then high again, and only then drives the frame low. Where the request falls within the serial clock cycle therefore changes the start delay, and the sample spacing can jitter by up to one serial clock period. A slip output flags every frame whose start delay differs from the one before it. A request that arrives while the block is busy is kept and served as soon as the current frame releases. A request that finds another one already waiting sets a sticky overrun flag. Divider and reload settings are taken from the configuration inputs only while the block is idle.

Top module: `frame_pacer`

## Requirements
- R1: While `rst` is high, and in the first sample after it has been high for a cycle, `sclk` is 1, `fs_n` is 1, and `frame_start`, `slip` and `overrun` are 0. This holds even when reset is applied in the middle of a frame.
- R2: `sclk` is high for (divider+1) master cycles and low for (divider+1) master cycles, which gives a period of 2×(divider+1). With a divider of 3 the period is 8. With a divider of 0 it is 2.
- R3: The interval timer fires every (reload+1) master cycles. When every request finds the block idle and (reload+1) is a multiple of the serial period, successive frames begin exactly (reload+1) cycles apart and `slip` stays 0.
- R4: A frame begins only after `sclk` has been seen high, then low, then high. `fs_n` falls in the master cycle after an `sclk` rising edge: in the two samples before the fall, `sclk` reads 0 and then 1.
- R5: `fs_n` stays low for exactly 16 serial clock periods, which is 16×2×(divider+1) master cycles, and one frame is issued per request.
- R6: `frame_start` is a one-cycle pulse that is high in exactly the cycle in which `fs_n` first reads low.
- R7: `slip` pulses together with `frame_start` when the delay from request to frame start differs from the previous frame's delay. It is never set on the first frame after reset.
- R8: A request that arrives while a frame or its wait sequence is in progress is held. The wait for the next frame begins in the cycle the current frame ends, so `fs_n` is high for exactly one serial period between the two frames.
- R9: `overrun` is set when a request arrives while one is already held. Once set, it stays 1 until reset.
- R10: Divider and reload values are captured only while idle. A change to `cfg_div` during a frame leaves the serial period unchanged until the block is idle again.
- R11: A request that arrives in the same cycle as a frame ends is served. It is neither lost nor counted as an overrun.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_div | input | DIV_W | Serial clock divider value |
| cfg_reload | input | RLD_W | Interval timer reload value |
| sclk | output | 1 | Serial clock, high after reset |
| fs_n | output | 1 | Active-low frame sync held for a whole word |
| frame_start | output | 1 | One-cycle strobe at frame start |
| slip | output | 1 | Pulses when the start delay changed from the previous frame |
| overrun | output | 1 | Sticky flag: a request arrived while one was already held |

## Verification
The timer request and the end of a frame can fall in the same master cycle. That cycle must then both release the frame and start the wait for the next one. To provoke this, the bench uses the fastest serial clock and sweeps the reload value over a range that carries the second request across the end of the first frame. In every run, the bench checks three things: a second frame appears within the expected window, it begins at least one serial period after the first frame releases, and `overrun` stays clear.

// File: rtl/fpt_pkg.sv
package fpt_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT_HI,
    ST_WAIT_LO,
    ST_WAIT_RISE,
    ST_FRAME
  } fseq_state_e;
endpackage

// File: rtl/fpt_sclk_gen.sv
module fpt_sclk_gen #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DIV_W-1:0] div,
  output logic             sclk
);
  logic [DIV_W-1:0] cnt_q;

  // Toggle after (div+1) master cycles; >= tolerates a smaller new divider.
  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      sclk  <= 1'b1;
    end else if (cnt_q >= div) begin
      cnt_q <= '0;
      sclk  <= ~sclk;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/fpt_interval_timer.sv
module fpt_interval_timer #(
  parameter int RLD_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [RLD_W-1:0] reload,
  output logic             req
);
  logic [RLD_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      req   <= 1'b0;
    end else if (cnt_q >= reload) begin
      cnt_q <= '0;
      req   <= 1'b1;
    end else begin
      cnt_q <= cnt_q + 1'b1;
      req   <= 1'b0;
    end
  end
endmodule

// File: rtl/fpt_frame_seq.sv
module fpt_frame_seq
  import fpt_pkg::*;
#(
  parameter int WORD_BITS = 16,
  parameter int DLY_W     = 11
) (
  input  logic clk,
  input  logic rst,
  input  logic sclk,
  input  logic req,
  output logic fs_n,
  output logic frame_start,
  output logic slip,
  output logic overrun,
  output logic idle
);
  localparam int BW = $clog2(WORD_BITS);

  fseq_state_e      state_q, state_d;
  logic [BW-1:0]    bit_q;
  logic [DLY_W-1:0] dly_q, prev_dly_q;
  logic             have_prev_q, pend_q, sclk_d;
  logic             rise, last, start, waiting, enter_wait;

  assign rise    = sclk & ~sclk_d;
  assign last    = (state_q == ST_FRAME) && rise && (bit_q == BW'(WORD_BITS - 1));
  assign start   = (state_q == ST_WAIT_RISE) && sclk;
  assign waiting = (state_q == ST_WAIT_HI) || (state_q == ST_WAIT_LO) ||
                   (state_q == ST_WAIT_RISE);
  assign enter_wait = ((state_q == ST_IDLE) && req) || (last && (pend_q || req));
  assign idle    = (state_q == ST_IDLE);

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE:      if (req) state_d = sclk ? ST_WAIT_LO : ST_WAIT_HI;
      ST_WAIT_HI:   if (sclk) state_d = ST_WAIT_LO;
      ST_WAIT_LO:   if (!sclk) state_d = ST_WAIT_RISE;
      ST_WAIT_RISE: if (sclk) state_d = ST_FRAME;
      ST_FRAME:     if (last) state_d = (pend_q || req) ? ST_WAIT_LO : ST_IDLE;
      default:      state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= ST_IDLE;
      sclk_d      <= 1'b1;
      bit_q       <= '0;
      dly_q       <= '0;
      prev_dly_q  <= '0;
      have_prev_q <= 1'b0;
      pend_q      <= 1'b0;
      fs_n        <= 1'b1;
      frame_start <= 1'b0;
      slip        <= 1'b0;
      overrun     <= 1'b0;
    end else begin
      state_q     <= state_d;
      sclk_d      <= sclk;
      frame_start <= start;
      slip        <= start && have_prev_q && (dly_q != prev_dly_q);

      if (start)     fs_n <= 1'b0;
      else if (last) fs_n <= 1'b1;

      if (start)                            bit_q <= '0;
      else if ((state_q == ST_FRAME) && rise) bit_q <= bit_q + 1'b1;

      // Start delay, counted from the cycle the request is taken up.
      if (enter_wait)   dly_q <= DLY_W'(1);
      else if (waiting) dly_q <= dly_q + 1'b1;

      if (start) begin
        prev_dly_q  <= dly_q;
        have_prev_q <= 1'b1;
      end

      if (last) begin
        pend_q <= pend_q && req;
      end else if (!idle && req) begin
        pend_q <= 1'b1;
        if (pend_q) overrun <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/frame_pacer.sv
module frame_pacer #(
  parameter int DIV_W     = 8,
  parameter int RLD_W     = 16,
  parameter int WORD_BITS = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DIV_W-1:0] cfg_div,
  input  logic [RLD_W-1:0] cfg_reload,
  output logic             sclk,
  output logic             fs_n,
  output logic             frame_start,
  output logic             slip,
  output logic             overrun
);
  localparam int DLY_W = DIV_W + 3;

  logic [DIV_W-1:0] div_q;
  logic [RLD_W-1:0] rld_q;
  logic             req, idle;

  always_ff @(posedge clk) begin
    if (rst || idle) begin
      div_q <= cfg_div;
      rld_q <= cfg_reload;
    end
  end

  fpt_sclk_gen #(.DIV_W(DIV_W)) u_sclk (
    .clk(clk), .rst(rst), .div(div_q), .sclk(sclk)
  );

  fpt_interval_timer #(.RLD_W(RLD_W)) u_tmr (
    .clk(clk), .rst(rst), .reload(rld_q), .req(req)
  );

  fpt_frame_seq #(.WORD_BITS(WORD_BITS), .DLY_W(DLY_W)) u_seq (
    .clk(clk), .rst(rst), .sclk(sclk), .req(req),
    .fs_n(fs_n), .frame_start(frame_start), .slip(slip),
    .overrun(overrun), .idle(idle)
  );
endmodule

// File: rtl/fpt_checker.sv
module fpt_checker #(
  parameter int DIV_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             sclk,
  input logic             fs_n,
  input logic             frame_start,
  input logic             slip,
  input logic             overrun,
  input logic [DIV_W-1:0] div_q
);
  logic             sclk_p;
  logic [DIV_W:0]   hcnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_p <= 1'b1;
      hcnt   <= '0;
    end else begin
      sclk_p <= sclk;
      hcnt   <= (sclk != sclk_p) ? '0 : hcnt + 1'b1;
    end
  end

  AST_HALF_PERIOD_IN_FRAME: assert property (@(posedge clk) disable iff (rst)
    !fs_n |-> (hcnt <= {1'b0, div_q})); // R2

  AST_START_AFTER_SCLK_HIGH: assert property (@(posedge clk) disable iff (rst)
    $fell(fs_n) |-> $past(sclk)); // R4

  AST_START_WITH_FS_FALL: assert property (@(posedge clk) disable iff (rst)
    frame_start |-> (!fs_n && $past(fs_n))); // R6

  AST_START_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    frame_start |=> !frame_start); // R6

  AST_SLIP_AT_START: assert property (@(posedge clk) disable iff (rst)
    slip |-> frame_start); // R7

  AST_OVERRUN_STICKY: assert property (@(posedge clk) disable iff (rst)
    overrun |=> overrun); // R9
endmodule

bind frame_pacer fpt_checker #(.DIV_W(DIV_W)) u_chk (
  .clk(clk), .rst(rst), .sclk(sclk), .fs_n(fs_n),
  .frame_start(frame_start), .slip(slip), .overrun(overrun), .div_q(div_q)
);

// File: tb/tb_frame_pacer.sv
module tb_frame_pacer;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  cfg_div = 8'd3;
  logic [15:0] cfg_reload = 16'd800;
  logic        sclk, fs_n, frame_start, slip, overrun;

  int     checks = 0;
  int     fails  = 0;
  longint cyc    = 0;
  bit     done   = 1'b0;

  frame_pacer dut (
    .clk(clk), .rst(rst), .cfg_div(cfg_div), .cfg_reload(cfg_reload),
    .sclk(sclk), .fs_n(fs_n), .frame_start(frame_start),
    .slip(slip), .overrun(overrun)
  );

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string rq, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic apply_reset(input int d, input int r);
    cfg_div = 8'(d);
    cfg_reload = 16'(r);
    rst = 1'b1;
    repeat (3) step();
    rst = 1'b0;
  endtask

  task automatic wait_fs_fall(input int lim, output bit found, output longint at);
    bit prev;
    found = 1'b0;
    at = 0;
    prev = fs_n;
    for (int i = 0; i < lim; i++) begin
      step();
      if (prev && !fs_n) begin
        found = 1'b1;
        at = cyc;
        return;
      end
      prev = fs_n;
    end
  endtask

  task automatic wait_sclk_rise(output longint at);
    bit prev;
    at = 0;
    prev = sclk;
    for (int i = 0; i < 2000; i++) begin
      step();
      if (!prev && sclk) begin
        at = cyc;
        return;
      end
      prev = sclk;
    end
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) step();
    chk(sclk && fs_n && !frame_start && !slip && !overrun, "R1 reset state",
        {sclk, fs_n, frame_start, slip, overrun}, 5'b11000);
  endtask

  task automatic t_sclk_period(input int d);
    longint a, b;
    int hi;
    apply_reset(d, 2000);
    wait_sclk_rise(a);
    hi = 0;
    while (sclk && hi < 1000) begin
      hi++;
      step();
    end
    wait_sclk_rise(b);
    chk(b - a == 2 * (d + 1), "R2 sclk period", b - a, 2 * (d + 1));
    chk(hi == d + 1, "R2 sclk high time", hi, d + 1);
  endtask

  task automatic t_frame_shape();
    bit s1, s2, found;
    int n;
    apply_reset(3, 800);
    s1 = sclk;
    s2 = sclk;
    found = 1'b0;
    for (int i = 0; i < 2000 && !found; i++) begin
      s2 = s1;
      s1 = sclk;
      step();
      if (!fs_n) found = 1'b1;
    end
    chk(found, "R5 frame issued", found, 1);
    chk(frame_start, "R6 strobe with fs_n fall", frame_start, 1);
    chk(!s2 && s1, "R4 sclk low then high before fall", {s2, s1}, 2'b01);
    n = 0;
    do begin
      n++;
      step();
      if (n == 1) chk(!frame_start, "R6 strobe one cycle", frame_start, 0);
    end while (!fs_n && n < 2000);
    chk(n == 128, "R5 fs_n low length", n, 128);
  endtask

  task automatic t_interval();
    bit f;
    longint a, b;
    apply_reset(3, 799);
    wait_fs_fall(3000, f, a);
    for (int k = 0; k < 5; k++) begin
      wait_fs_fall(3000, f, b);
      chk(f && (b - a == 800), "R3 equal frame spacing", b - a, 800);
      chk(!slip, "R3 no slip at equal spacing", slip, 0);
      a = b;
    end
  endtask

  task automatic t_slip();
    bit f;
    longint a, b;
    int nslip;
    apply_reset(3, 803);
    wait_fs_fall(3000, f, a);
    chk(f && !slip, "R7 no slip on first frame", slip, 0);
    nslip = 0;
    for (int k = 0; k < 8; k++) begin
      wait_fs_fall(3000, f, b);
      chk(f && (slip == ((b - a) != 804)), "R7 slip matches spacing change",
          slip, ((b - a) != 804));
      chk((b - a >= 804 - 16) && (b - a <= 804 + 16), "R3 spacing near interval", b - a, 804);
      if (slip) nslip++;
      a = b;
    end
    chk(nslip > 0, "R7 slips seen", nslip, 1);
  endtask

  task automatic t_pending();
    bit f;
    longint a;
    int gap;
    bit stuck;
    apply_reset(3, 99);
    wait_fs_fall(3000, f, a);
    while (!fs_n) step();
    gap = 0;
    while (fs_n && gap < 1000) begin
      gap++;
      step();
    end
    chk(gap == 8, "R8 pending served one period after release", gap, 8);
    chk(!overrun, "R9 no overrun with one held request", overrun, 0);
    repeat (700) step();
    chk(overrun, "R9 overrun set", overrun, 1);
    stuck = 1'b1;
    for (int i = 0; i < 300; i++) begin
      step();
      if (!overrun) stuck = 1'b0;
    end
    chk(stuck, "R9 overrun sticky", stuck, 1);
    while (fs_n) step();
    rst = 1'b1;
    step();
    chk(sclk && fs_n && !overrun && !frame_start && !slip, "R1 reset mid frame",
        {sclk, fs_n, overrun}, 3'b110);
    rst = 1'b0;
  endtask

  task automatic t_config();
    bit f;
    longint a, r1, r2;
    apply_reset(3, 999);
    wait_fs_fall(3000, f, a);
    cfg_div = 8'd1;
    wait_sclk_rise(r1);
    wait_sclk_rise(r2);
    chk(r2 - r1 == 8, "R10 divider held during frame", r2 - r1, 8);
    while (!fs_n) step();
    repeat (6) step();
    wait_sclk_rise(r1);
    wait_sclk_rise(r2);
    chk(r2 - r1 == 4, "R10 divider taken when idle", r2 - r1, 4);
  endtask

  task automatic t_coincide();
    bit f1, f2;
    longint a, b;
    for (int r = 25; r <= 45; r++) begin
      apply_reset(0, r);
      wait_fs_fall(300, f1, a);
      wait_fs_fall(r + 60, f2, b);
      chk(f1 && f2, "R11 second frame issued", f2, 1);
      chk(!overrun, "R11 no overrun", overrun, 0);
      chk(b - a >= 34, "R11 gap at least one period", b - a, 34);
    end
  endtask

  initial begin
    #(8 * 190000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 190000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_sclk_period(3);
    t_sclk_period(0);
    t_frame_shape();
    t_interval();
    t_slip();
    t_pending();
    t_config();
    t_coincide();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule